// File: doc/BRIEF.md
# ALU Status Flag Generator

This block sits beside an 8-bit arithmetic/logic unit. For each operation it forms the 8-bit result from two operands and a carry input, derives five condition flags from that operation, and keeps those flags in a register. The register changes only on a clock edge where the update enable is high. The flags are packed into an 8-bit status byte. Three of its bits have no flag behind them and read as fixed values.

For stack transfers, the accumulator value and the status byte travel together as one 16-bit word. The push word places the accumulator in the high byte. A pop loads the flag register from the low byte of a supplied word and returns the high byte as the accumulator value to restore. The block does not decode instructions and holds no general registers.

The reset input is asynchronous and active low. Its release is synchronised to the clock inside the block.

Top module: `alu_flag_unit`

## Requirements
- R1: The operation code selects the operation: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 compare, 5 AND, 6 OR, 7 XOR, 8 NOT (of the A operand), 9 increment A, 10 decrement A. The result is modulo 256. For add and add with carry, carry is set on a carry out of bit 7. For subtract, subtract with borrow and compare, carry is set on a borrow. Otherwise carry is clear. Add with carry and subtract with borrow use the carry input port.
- R2: On an updating operation, the sign flag takes bit 7 of the computed value.
- R3: On an updating operation, the zero flag is set only when the computed value is all zeros.
- R4: On an updating operation, the parity flag is set when the computed value holds an even number of ones, and cleared when the number is odd.
- R5: For additions and increment, the auxiliary flag is set on a carry out of bit 3 into bit 4. For subtractions, compare and decrement, it is set on a borrow from bit 4 into bit 3. Logic operations clear it.
- R6: The status byte is {sign, zero, 0, aux, 0, parity, 1, carry}, from bit 7 down to bit 0. Bits 5 and 3 always read 0 and bit 1 always reads 1.
- R7: AND, OR, XOR and NOT clear the carry flag. Increment and decrement leave the carry flag unchanged and update the other four flags.
- R8: Compare sets the flags from A minus B, and the result port shows A unchanged.
- R9: While the update enable is low, every flag holds its value. Codes 11 to 15 leave every flag unchanged and pass A to the result.
- R10: The push word is {A operand, status byte}. A pop loads the flags from the low byte of the pop word at the next edge, and takes precedence over an update in the same cycle. The accumulator-restore output is the high byte of the pop word.
- R11: While reset is asserted, all five flags are clear and the status byte reads 8'h02.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_code | input | 4 | Operation select |
| op_a | input | 8 | A operand (accumulator value) |
| op_b | input | 8 | B operand |
| carry_in | input | 1 | Carry/borrow input for add with carry and subtract with borrow |
| flag_en | input | 1 | Flag update enable |
| pop_load | input | 1 | Load flags from pop word |
| pop_data | input | 16 | Word popped from the stack |
| result | output | 8 | Operation result |
| flag_sign | output | 1 | Sign flag |
| flag_zero | output | 1 | Zero flag |
| flag_aux | output | 1 | Auxiliary (nibble) carry flag |
| flag_parity | output | 1 | Even parity flag |
| flag_carry | output | 1 | Carry / borrow flag |
| status_word | output | 8 | Packed status byte |
| push_data | output | 16 | Accumulator and status word for a push |
| acc_restore | output | 8 | Accumulator value taken from the pop word |

## Verification
The operand patterns are chosen so that each flag is tested on its own.

- Sums that wrap to zero set carry, aux and zero together. Nibble-edge operands such as 0x0F+0x01 and 0x7F+1 set aux without carry.
- Subtractions below zero and borrow-in of 1 on equal operands show the borrow direction of both carry and aux.
- Result values with odd and even numbers of ones test parity independently of sign.
- Compares of equal and unequal operands show that the result stays A while the flags follow the difference.
- Increments and decrements after carry has been set, and after it has been cleared, show that carry is held.
- Pops of words with the fixed bits set show that those bits are ignored.
- A pop issued together with an update shows which one takes precedence.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBB = 4'd3,
    OP_CMP = 4'd4,
    OP_AND = 4'd5,
    OP_OR  = 4'd6,
    OP_XOR = 4'd7,
    OP_NOT = 4'd8,
    OP_INC = 4'd9,
    OP_DEC = 4'd10
  } alu_op_e;

  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } flags_t;

  localparam int STATUS_W = 8;

  function automatic logic [STATUS_W-1:0] pack_status(input flags_t f);
    return {f.s, f.z, 1'b0, f.ac, 1'b0, f.p, 1'b1, f.cy};
  endfunction

  function automatic flags_t unpack_status(input logic [STATUS_W-1:0] w);
    flags_t f;
    f.s  = w[7];
    f.z  = w[6];
    f.ac = w[4];
    f.p  = w[2];
    f.cy = w[0];
    return f;
  endfunction

endpackage

// File: rtl/alu_rst_sync.sv
module alu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [3:0]        op_code,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output flags_t            nf,
  output logic              cy_upd,
  output logic              op_ok
);
  localparam int NIB_W = 4;

  logic [DATA_W-1:0] rhs;
  logic              c_use;
  logic              is_arith;
  logic              is_sub;
  logic              keep_a;
  logic [DATA_W-1:0] logic_val;
  logic [DATA_W:0]   add_w;
  logic [DATA_W:0]   sub_w;
  logic [NIB_W:0]    add_n;
  logic [NIB_W:0]    sub_n;
  logic [DATA_W-1:0] calc;

  always_comb begin
    rhs       = b;
    c_use     = 1'b0;
    is_arith  = 1'b0;
    is_sub    = 1'b0;
    keep_a    = 1'b0;
    cy_upd    = 1'b1;
    op_ok     = 1'b1;
    logic_val = a;
    case (op_code)
      OP_ADD: is_arith = 1'b1;
      OP_ADC: begin is_arith = 1'b1; c_use = cin; end
      OP_SUB: begin is_arith = 1'b1; is_sub = 1'b1; end
      OP_SBB: begin is_arith = 1'b1; is_sub = 1'b1; c_use = cin; end
      OP_CMP: begin is_arith = 1'b1; is_sub = 1'b1; keep_a = 1'b1; end
      OP_AND: logic_val = a & b;
      OP_OR:  logic_val = a | b;
      OP_XOR: logic_val = a ^ b;
      OP_NOT: logic_val = ~a;
      OP_INC: begin is_arith = 1'b1; rhs = {{(DATA_W-1){1'b0}}, 1'b1}; cy_upd = 1'b0; end
      OP_DEC: begin
        is_arith = 1'b1; is_sub = 1'b1;
        rhs = {{(DATA_W-1){1'b0}}, 1'b1}; cy_upd = 1'b0;
      end
      default: begin op_ok = 1'b0; cy_upd = 1'b0; end
    endcase
  end

  always_comb begin
    add_w = {1'b0, a} + {1'b0, rhs} + {{DATA_W{1'b0}}, c_use};
    sub_w = {1'b0, a} - {1'b0, rhs} - {{DATA_W{1'b0}}, c_use};
    add_n = {1'b0, a[NIB_W-1:0]} + {1'b0, rhs[NIB_W-1:0]} + {{NIB_W{1'b0}}, c_use};
    sub_n = {1'b0, a[NIB_W-1:0]} - {1'b0, rhs[NIB_W-1:0]} - {{NIB_W{1'b0}}, c_use};
  end

  always_comb begin
    if (is_arith) calc = is_sub ? sub_w[DATA_W-1:0] : add_w[DATA_W-1:0];
    else          calc = logic_val;
    res   = (keep_a || !op_ok) ? a : calc;
    nf.s  = calc[DATA_W-1];
    nf.z  = (calc == '0);
    nf.p  = ~^calc;
    nf.ac = is_arith && (is_sub ? sub_n[NIB_W] : add_n[NIB_W]);
    nf.cy = is_arith && (is_sub ? sub_w[DATA_W] : add_w[DATA_W]);
  end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import alu_flag_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   upd_en,
  input  logic   cy_upd,
  input  flags_t nf,
  input  logic   pop_load,
  input  flags_t pop_flags,
  output flags_t flags_q
);
  flags_t flags_d;

  always_comb begin
    flags_d = flags_q;
    if (pop_load) begin
      flags_d = pop_flags;
    end else if (upd_en) begin
      flags_d.s  = nf.s;
      flags_d.z  = nf.z;
      flags_d.ac = nf.ac;
      flags_d.p  = nf.p;
      if (cy_upd) flags_d.cy = nf.cy;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [3:0]             op_code,
  input  logic [DATA_W-1:0]      op_a,
  input  logic [DATA_W-1:0]      op_b,
  input  logic                   carry_in,
  input  logic                   flag_en,
  input  logic                   pop_load,
  input  logic [DATA_W+7:0]      pop_data,
  output logic [DATA_W-1:0]      result,
  output logic                   flag_sign,
  output logic                   flag_zero,
  output logic                   flag_aux,
  output logic                   flag_parity,
  output logic                   flag_carry,
  output logic [STATUS_W-1:0]    status_word,
  output logic [DATA_W+7:0]      push_data,
  output logic [DATA_W-1:0]      acc_restore
);
  logic   rst_sync_n;
  flags_t nf;
  flags_t flags_q;
  logic   cy_upd;
  logic   op_ok;

  alu_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  alu_core #(.DATA_W(DATA_W)) u_core (
    .op_code (op_code),
    .a       (op_a),
    .b       (op_b),
    .cin     (carry_in),
    .res     (result),
    .nf      (nf),
    .cy_upd  (cy_upd),
    .op_ok   (op_ok)
  );

  alu_flag_reg u_flags (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .upd_en    (flag_en && op_ok),
    .cy_upd    (cy_upd),
    .nf        (nf),
    .pop_load  (pop_load),
    .pop_flags (unpack_status(pop_data[STATUS_W-1:0])),
    .flags_q   (flags_q)
  );

  assign flag_sign   = flags_q.s;
  assign flag_zero   = flags_q.z;
  assign flag_aux    = flags_q.ac;
  assign flag_parity = flags_q.p;
  assign flag_carry  = flags_q.cy;
  assign status_word = pack_status(flags_q);
  assign push_data   = {op_a, status_word};
  assign acc_restore = pop_data[DATA_W+7:STATUS_W];
endmodule

// File: rtl/alu_flag_unit_chk.sv
module alu_flag_unit_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        op_code,
  input logic [DATA_W-1:0] op_a,
  input logic              flag_en,
  input logic              pop_load,
  input logic [DATA_W+7:0] pop_data,
  input logic [DATA_W-1:0] result,
  input logic              flag_zero,
  input logic              flag_carry,
  input logic [7:0]        status_word
);
  a_r9_hold_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_en && !pop_load) |=> $stable(status_word));

  a_r9_reserved_passes_a: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code > 4'd10) |-> (result == op_a));

  a_r7_incdec_keeps_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_en && !pop_load && (op_code == 4'd9 || op_code == 4'd10))
    |=> (flag_carry == $past(flag_carry)));

  a_r7_logic_clears_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_en && !pop_load && op_code >= 4'd5 && op_code <= 4'd8) |=> !flag_carry);

  a_r8_compare_keeps_a: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 4'd4) |-> (result == op_a));

  a_r3_zero_tracks_result: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_en && !pop_load && op_code <= 4'd10 && op_code != 4'd4)
    |=> (flag_zero == ($past(result) == '0)));

  a_r10_pop_loads_status: assert property (@(posedge clk) disable iff (!rst_n)
    pop_load |=> (status_word == (($past(pop_data[7:0]) & 8'hD5) | 8'h02)));
endmodule

bind alu_flag_unit alu_flag_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .op_code     (op_code),
  .op_a        (op_a),
  .flag_en     (flag_en),
  .pop_load    (pop_load),
  .pop_data    (pop_data),
  .result      (result),
  .flag_zero   (flag_zero),
  .flag_carry  (flag_carry),
  .status_word (status_word)
);

// File: tb/tb_alu_flag_unit.sv
module tb_alu_flag_unit;
  logic        clk;
  logic        rst_n;
  logic [3:0]  op_code;
  logic [7:0]  op_a, op_b;
  logic        carry_in, flag_en, pop_load;
  logic [15:0] pop_data;
  logic [7:0]  result;
  logic        flag_sign, flag_zero, flag_aux, flag_parity, flag_carry;
  logic [7:0]  status_word;
  logic [15:0] push_data;
  logic [7:0]  acc_restore;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  alu_flag_unit dut (
    .clk(clk), .rst_n(rst_n), .op_code(op_code), .op_a(op_a), .op_b(op_b),
    .carry_in(carry_in), .flag_en(flag_en), .pop_load(pop_load),
    .pop_data(pop_data), .result(result), .flag_sign(flag_sign),
    .flag_zero(flag_zero), .flag_aux(flag_aux), .flag_parity(flag_parity),
    .flag_carry(flag_carry), .status_word(status_word),
    .push_data(push_data), .acc_restore(acc_restore)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {op, a, b, cin, expected result, expected status}
  localparam logic [36:0] VEC [0:17] = '{
    {4'd0,  8'h3A, 8'hC6, 1'b0, 8'h00, 8'h57},
    {4'd1,  8'h0F, 8'h01, 1'b1, 8'h11, 8'h16},
    {4'd2,  8'h05, 8'h07, 1'b0, 8'hFE, 8'h93},
    {4'd3,  8'h50, 8'h20, 1'b1, 8'h2F, 8'h12},
    {4'd4,  8'h40, 8'h40, 1'b0, 8'h40, 8'h46},
    {4'd4,  8'h10, 8'h20, 1'b0, 8'h10, 8'h87},
    {4'd5,  8'hF0, 8'h3C, 1'b0, 8'h30, 8'h06},
    {4'd6,  8'h81, 8'h00, 1'b0, 8'h81, 8'h86},
    {4'd7,  8'hAA, 8'hAA, 1'b0, 8'h00, 8'h46},
    {4'd8,  8'h0F, 8'h00, 1'b0, 8'hF0, 8'h86},
    {4'd0,  8'hFF, 8'h01, 1'b0, 8'h00, 8'h57},
    {4'd9,  8'h7F, 8'h00, 1'b0, 8'h80, 8'h93},
    {4'd10, 8'h00, 8'h00, 1'b0, 8'hFF, 8'h97},
    {4'd9,  8'hFF, 8'h00, 1'b0, 8'h00, 8'h57},
    {4'd0,  8'h12, 8'h34, 1'b0, 8'h46, 8'h02},
    {4'd10, 8'h01, 8'h00, 1'b0, 8'h00, 8'h46},
    {4'd1,  8'h7F, 8'h00, 1'b1, 8'h80, 8'h92},
    {4'd3,  8'h00, 8'h00, 1'b1, 8'hFF, 8'h97}
  };

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic cin, input logic fe, input logic pl,
                       input logic [15:0] pd);
    @(negedge clk);
    op_code = op; op_a = a; op_b = b; carry_in = cin;
    flag_en = fe; pop_load = pl; pop_data = pd;
    @(posedge clk);
    #2;
  endtask

  initial begin
    rst_n = 1'b0; op_code = 4'd0; op_a = 8'h00; op_b = 8'h00;
    carry_in = 1'b0; flag_en = 1'b0; pop_load = 1'b0; pop_data = 16'h0000;
    #18;
    chk("R11 reset status", {8'h00, status_word}, 16'h0002);
    chk("R11 reset flags", {11'd0, flag_sign, flag_zero, flag_aux, flag_parity, flag_carry}, 16'h0000);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);

    for (int i = 0; i < 18; i++) begin
      logic [36:0] v;
      v = VEC[i];
      apply(v[36:33], v[32:25], v[24:17], v[16], 1'b1, 1'b0, 16'h0000);
      chk($sformatf("R1/R8 result vec%0d", i), {8'h00, result}, {8'h00, v[15:8]});
      chk($sformatf("R6 status vec%0d", i), {8'h00, status_word}, {8'h00, v[7:0]});
      chk($sformatf("R1 carry vec%0d", i), {15'd0, flag_carry}, {15'd0, v[0]});
      chk($sformatf("R2 sign vec%0d", i), {15'd0, flag_sign}, {15'd0, v[7]});
      chk($sformatf("R3 zero vec%0d", i), {15'd0, flag_zero}, {15'd0, v[6]});
      chk($sformatf("R4 parity vec%0d", i), {15'd0, flag_parity}, {15'd0, v[2]});
      chk($sformatf("R5 aux vec%0d", i), {15'd0, flag_aux}, {15'd0, v[4]});
    end

    // R9: enable low holds flags even though the result is computed
    apply(4'd0, 8'hFF, 8'h01, 1'b0, 1'b0, 1'b0, 16'h0000);
    chk("R9 hold status", {8'h00, status_word}, 16'h0097);
    chk("R1 result while held", {8'h00, result}, 16'h0000);
    // R9: reserved code
    apply(4'd12, 8'h5A, 8'h33, 1'b1, 1'b1, 1'b0, 16'h0000);
    chk("R9 reserved result", {8'h00, result}, 16'h005A);
    chk("R9 reserved status", {8'h00, status_word}, 16'h0097);
    chk("R10 push word", push_data, 16'h5A97);
    // R10: pop wins over update in the same cycle
    apply(4'd0, 8'h01, 8'h01, 1'b0, 1'b1, 1'b1, 16'hA5FF);
    chk("R10 pop status", {8'h00, status_word}, 16'h00D7);
    chk("R10 acc restore", {8'h00, acc_restore}, 16'h00A5);
    // R7: AND clears carry and aux
    apply(4'd5, 8'hFF, 8'h01, 1'b0, 1'b1, 1'b0, 16'h0000);
    chk("R7 logic clears carry", {8'h00, status_word}, 16'h0002);
    // R6: fixed bits of a popped word are ignored
    apply(4'd0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 16'h1228);
    chk("R6 fixed bits", {8'h00, status_word}, 16'h0002);
    chk("R10 acc restore 2", {8'h00, acc_restore}, 16'h0012);
    // R7: decrement keeps carry set by a borrow
    apply(4'd2, 8'h00, 8'h01, 1'b0, 1'b1, 1'b0, 16'h0000);
    chk("R1 borrow", {8'h00, status_word}, 16'h0097);
    apply(4'd10, 8'h80, 8'h00, 1'b0, 1'b1, 1'b0, 16'h0000);
    chk("R7 dec keeps carry", {8'h00, status_word}, 16'h0013);
    chk("R5 dec half borrow", {8'h00, result}, 16'h007F);
    // R8: compare unequal without borrow
    apply(4'd4, 8'h05, 8'h03, 1'b0, 1'b1, 1'b0, 16'h0000);
    chk("R8 compare status", {8'h00, status_word}, 16'h0002);
    chk("R8 compare result", {8'h00, result}, 16'h0005);
    // R11: asynchronous reset mid-run
    apply(4'd0, 8'hFF, 8'h01, 1'b0, 1'b1, 1'b0, 16'h0000);
    chk("R1 pre-reset", {8'h00, status_word}, 16'h0057);
    @(negedge clk); rst_n = 1'b0; flag_en = 1'b0;
    #1;
    chk("R11 async reset", {8'h00, status_word}, 16'h0002);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog got=timeout exp=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule